// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block connects a synchronous host request port to a clockless 512K x 8 static RAM. For each accepted request it runs one read or write cycle on the memory. It drives the active-low chip select, write enable and output enable strobes, and the address. It also drives a split data bus made of an output value, an output enable and a sampled input. Every phase of a cycle lasts a whole number of clocks. That number is the ceiling of the memory's nanosecond minimum divided by the clock period `CLK_NS`.

A write runs in three phases. First comes a setup phase, where chip select is low and the address and data are already driven. Next comes the write pulse, where write enable is also low. Last comes a hold phase, where both strobes are released while the data stays on the bus. A read holds chip select and output enable low for the access time, captures the data, and then waits out the output turn-off time before the controller goes idle. The host hands over a request with `req_i`. The request is taken on a rising edge where `busy_o` is low. If the host raises a request while a cycle is running, the request is held off, not dropped.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high (inactive), the data output enable is low, and `busy_o` and `done_o` are low.
- R2: In a write, write enable is low only while chip select is low and the data output enable is high. It stays low for PULSE = max(ceil(max(tWP,tDW)/CLK_NS), ceil(max(tCW,tAW)/CLK_NS) - SETUP) cycles, which is 4 at the defaults (CLK_NS=10).
- R3: Chip select falls SETUP = max(1, ceil(tAS/CLK_NS)) cycles before write enable falls, which is 1 at the defaults. The address equals the request address whenever chip select is low. Address and data stay stable throughout the write pulse. Data stays driven for one hold phase after write enable rises, so it is driven for 6 cycles in total at the defaults.
- R4: Output enable stays high for the whole write cycle. The data output enable is never high while output enable is low.
- R5: A write keeps chip select low for SETUP+PULSE cycles (5 at the defaults). It keeps `busy_o` high for at least ceil(tWC/CLK_NS) cycles and for at least SETUP+PULSE plus a recovery phase, which is 6 at the defaults.
- R6: In a read, chip select and output enable fall in the same cycle and stay low for ACC = ceil(max(tAA,tCO,tRC)/CLK_NS) cycles (6 at the defaults). Write enable and the data output enable stay inactive throughout.
- R7: Read data is sampled on the clock edge that ends the access phase. It appears on `rdata_o` in the cycle where `done_o` is high.
- R8: After a read, the controller stays busy for TURN = max(1, ceil(tOHZ/CLK_NS)) cycles with the strobes released, so that the memory's outputs turn off before the next cycle. At the defaults the read keeps `busy_o` high for 8 cycles.
- R9: A request is taken only on a rising edge where `busy_o` is low. A request raised while `busy_o` is high is served once the current cycle ends.
- R10: `done_o` is high for exactly one clock per served request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until taken |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Request address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | High while a cycle runs; requests are not taken |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Captured read data |
| mem_addr_o | output | 19 | Memory address bus |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Enables the data driver |
| mem_dq_i | input | 8 | Data sampled from the memory |

## Verification
The assertions check the following on every cycle:
- the data driver never overlaps a low output enable;
- write enable is low only inside a selected, driven window;
- address and data hold still across the write pulse;
- data remains driven as write enable rises;
- read strobes fall together;
- a taken request raises `busy_o`;
- `done_o` lasts one clock.

Phase lengths in cycles, the captured read value, the turnaround after a read, and serving a held-off request need whole scenarios. The bench checks these against a memory model that returns valid data only after the access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  function automatic int cyc_ceil(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_ctl_t pins_of(phase_e p);
    pin_ctl_t c;
    case (p)
      ST_WSETUP: c = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WPULSE: c = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      ST_WHOLD:  c = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      ST_RACC:   c = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:   c = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int SETUP_C = 1,
  parameter int PULSE_C = 4,
  parameter int HOLD_C  = 1,
  parameter int ACC_C   = 6,
  parameter int TURN_C  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output phase_e           state_d_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_d_o,
  output logic             busy_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o   = 1'b1;
        load_o     = 1'b1;
        state_d    = we_i ? ST_WSETUP : ST_RACC;
        load_val_o = we_i ? CNT_W'(SETUP_C - 1) : CNT_W'(ACC_C - 1);
      end
      ST_WSETUP: if (expired_i) begin
        state_d    = ST_WPULSE;
        load_o     = 1'b1;
        load_val_o = CNT_W'(PULSE_C - 1);
      end
      ST_WPULSE: if (expired_i) begin
        state_d    = ST_WHOLD;
        load_o     = 1'b1;
        load_val_o = CNT_W'(HOLD_C - 1);
      end
      ST_WHOLD: if (expired_i) begin
        state_d  = ST_IDLE;
        done_d_o = 1'b1;
      end
      ST_RACC: if (expired_i) begin
        state_d    = ST_RTURN;
        load_o     = 1'b1;
        load_val_o = CNT_W'(TURN_C - 1);
        capture_o  = 1'b1;
        done_d_o   = 1'b1;
      end
      ST_RTURN: if (expired_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign busy_o    = (state_q != ST_IDLE);
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  phase_e            state_d_i,
  input  logic              capture_i,
  input  logic              done_d_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output pin_ctl_t          ctl_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  // strobes registered from the next phase: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= pins_of(ST_IDLE);
      done_o <= 1'b0;
    end else begin
      ctl_o  <= pins_of(state_d_i);
      done_o <= done_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= mem_dq_i;
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WC_NS = 55,
  parameter int T_CW_NS = 50,
  parameter int T_AW_NS = 50,
  parameter int T_WP_NS = 40,
  parameter int T_DW_NS = 25,
  parameter int T_AS_NS = 0,
  parameter int T_WR_NS = 5,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_CO_NS = 55,
  parameter int T_OHZ_NS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int SETUP_C = imax(1, cyc_ceil(T_AS_NS, CLK_NS));
  localparam int PULSE_C = imax(cyc_ceil(imax(T_WP_NS, T_DW_NS), CLK_NS),
                                cyc_ceil(imax(T_CW_NS, T_AW_NS), CLK_NS) - SETUP_C);
  localparam int HOLD_C  = imax(imax(1, cyc_ceil(T_WR_NS, CLK_NS)),
                                cyc_ceil(T_WC_NS, CLK_NS) - SETUP_C - PULSE_C);
  localparam int ACC_C   = imax(1, cyc_ceil(imax(imax(T_AA_NS, T_CO_NS), T_RC_NS), CLK_NS));
  localparam int TURN_C  = imax(1, cyc_ceil(T_OHZ_NS, CLK_NS));
  localparam int MAX_C   = imax(imax(imax(SETUP_C, PULSE_C), imax(HOLD_C, ACC_C)), TURN_C);
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic             load, expired, accept, capture, done_d;
  logic [CNT_W-1:0] load_val;
  phase_e           state_d;
  pin_ctl_t         ctl;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val), .expired_o(expired)
  );

  sram_cycle_fsm #(
    .CNT_W(CNT_W), .SETUP_C(SETUP_C), .PULSE_C(PULSE_C),
    .HOLD_C(HOLD_C), .ACC_C(ACC_C), .TURN_C(TURN_C)
  ) i_fsm (
    .clk_i, .rst_ni, .req_i, .we_i,
    .expired_i(expired), .load_o(load), .load_val_o(load_val),
    .state_d_o(state_d), .accept_o(accept), .capture_o(capture),
    .done_d_o(done_d), .busy_o(busy_o)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk_i, .rst_ni,
    .accept_i(accept), .addr_i, .wdata_i,
    .state_d_i(state_d), .capture_i(capture), .done_d_i(done_d),
    .mem_dq_i, .mem_addr_o, .mem_dq_o,
    .ctl_o(ctl), .rdata_o, .done_o
  );

  assign mem_cs_no   = ctl.cs_n;
  assign mem_we_no   = ctl.we_n;
  assign mem_oe_no   = ctl.oe_n;
  assign mem_dq_oe_o = ctl.dq_oe;
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  // R4
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_dq_oe_o && mem_we_no));

  // R2
  we_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs_no && mem_dq_oe_o));

  // R3
  wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  // R3
  wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(!mem_cs_no) && $stable(mem_addr_o) && $past(mem_dq_oe_o)));

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  // R6
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> ($fell(mem_cs_no) && mem_we_no));

  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  // Expected cycle counts at CLK_NS=10, derived from the requirement formulas
  localparam int E_PULSE = 4, E_WCS = 5, E_WDQ = 6, E_WBUSY = 6;
  localparam int E_ACC = 6, E_RBUSY = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] maddr;
  logic cs_n, we_n, oe_n, dq_oe;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl i_sram_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_cs_no(cs_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model: data valid only once access time has elapsed
  logic [DW-1:0] mem [int];
  int rd_cnt = 0;
  logic [DW-1:0] rd_val = '0;
  always @(negedge clk) begin
    if (!cs_n && !we_n && dq_oe) mem[int'(maddr)] = dq_o;
    if (!cs_n && !oe_n && we_n) begin
      rd_cnt = rd_cnt + 1;
      rd_val = mem.exists(int'(maddr)) ? mem[int'(maddr)] : 8'h00;
    end else rd_cnt = 0;
  end
  assign dq_i = (rd_cnt >= E_ACC) ? rd_val : 8'hEE;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // statistics of one transaction
  int s_welo, s_cslo, s_oelo, s_dqoe, s_cont, s_busy, s_done, s_bad;
  logic [DW-1:0] s_rdata;

  task automatic run_txn(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    s_welo = 0; s_cslo = 0; s_oelo = 0; s_dqoe = 0;
    s_cont = 0; s_busy = 0; s_done = 0; s_bad = 0; s_rdata = '0;
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!we_n) begin
        s_welo++;
        if (dq_o != d) s_bad++;
      end
      if (!cs_n) begin
        s_cslo++;
        if (maddr != a) s_bad++;
      end
      if (!oe_n) s_oelo++;
      if (dq_oe) s_dqoe++;
      if (dq_oe && !oe_n) s_cont++;
      if (busy) s_busy++;
      if (done) begin s_done++; s_rdata = rdata; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    // R1
    check(cs_n && we_n && oe_n, "R1 strobes idle", {cs_n, we_n, oe_n}, 7);
    check(!dq_oe, "R1 dq_oe low", dq_oe, 0);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    run_txn(1'b1, a, d);
    check(s_welo == E_PULSE, "R2 write pulse cycles", s_welo, E_PULSE);
    check(s_bad == 0, "R3 address/data during write", s_bad, 0);
    check(s_dqoe == E_WDQ, "R3 data drive cycles", s_dqoe, E_WDQ);
    check(s_oelo == 0 && s_cont == 0, "R4 oe high in write", s_oelo, 0);
    check(s_cslo == E_WCS, "R5 cs low cycles", s_cslo, E_WCS);
    check(s_busy == E_WBUSY, "R5 write busy cycles", s_busy, E_WBUSY);
    check(s_done == 1, "R10 write done pulses", s_done, 1);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    run_txn(1'b0, a, 8'h00);
    check(s_cslo == E_ACC && s_oelo == E_ACC, "R6 read strobe cycles", s_oelo, E_ACC);
    check(s_welo == 0 && s_dqoe == 0, "R6 no drive in read", s_dqoe, 0);
    check(s_bad == 0, "R6 read address", s_bad, 0);
    check(s_rdata == exp, "R7 read data", s_rdata, exp);
    check(s_busy == E_RBUSY, "R8 read busy incl turnaround", s_busy, E_RBUSY);
    check(s_done == 1, "R10 read done pulses", s_done, 1);
  endtask

  // R9: request raised during a write is held off, then served
  task automatic t_holdoff();
    int waited = 0;
    bit seen_done = 0;
    logic [DW-1:0] got = '0;
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h0_0ABC; wdata = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = 19'h7_FFFF; wdata = 8'h00;  // read kept pending
    check(busy == 1'b1, "R9 busy while cycle runs", busy, 1);
    while (busy) begin @(negedge clk); waited++; end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    check(busy == 1'b1, "R9 pending request taken", busy, 1);
    for (int i = 0; i < 12; i++) begin
      if (done && !seen_done) begin seen_done = 1; got = rdata; end
      @(negedge clk);
    end
    check(waited > 0, "R9 request held off", waited, 1);
    check(seen_done && got == 8'hA5, "R9 held request served", got, 8'hA5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(19'h0_0000, 8'h55);
    t_write(19'h7_FFFF, 8'hA5);
    t_write(19'h2_AAAA, 8'hFF);
    t_read(19'h0_0000, 8'h55);
    t_read(19'h2_AAAA, 8'hFF);
    t_write(19'h0_0000, 8'h0F);  // write right after a read
    t_read(19'h0_0000, 8'h0F);
    t_read(19'h1_2345, 8'h00);   // never written
    t_holdoff();
    t_read(19'h0_0ABC, 8'h3C);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule